// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block is an 8-bit general-purpose I/O port on a simple memory-mapped register bus. Its data register is reached through a window of 256 word addresses. The eight address bits just above the byte offset act as a per-pin bit-enable. One store can therefore set, clear, or both set and clear any subset of pins, and the pins outside the subset keep their values. Software needs no read-modify-write sequence, so an interrupt handler that touches other pins of the same port cannot corrupt the update.

Reads through the same window use the address bits as a mask in the same way. A pin whose mask bit is clear reads as zero. A pin whose mask bit is set returns the driven output value if the pin is an output, or its synchronised input value if the pin is an input. A direction register outside the window selects, pin by pin, whether the pin drives. The direction register also appears directly as the per-pin output enable.

Top module: `gpio_mask_port`

## Requirements
- R1: While reset is held, and after it is released, `pin_out` and `pin_oe` are all zeros and `rd_data` is zero.
- R2: A write strobe with address bits [11:10] = 00 is a data-window write, and address bits [9:2] form the mask. At the next clock edge, each pin n whose mask bit n is 1 takes `bus_wdata[n]`. Each pin whose mask bit is 0 keeps its previous output value.
- R3: A data-window write with mask 0 leaves `pin_out` unchanged.
- R4: Address bits [1:0] have no effect on any access.
- R5: A read strobe returns data on `rd_data` from the clock edge that samples the strobe, and `rd_data` holds until the next read. For a data-window read, bit n is 0 where mask bit n is 0. Where mask bit n is 1, bit n is the output value if direction bit n is 1, or the synchronised input if direction bit n is 0. Bits 31:8 are zero.
- R6: The direction register is at address 0x400, which means bits [11:10] = 01 and bits [9:2] = 0. A write there loads all eight bits from `bus_wdata[7:0]` with no mask applied. A read there returns the register. `pin_oe` equals the register, and bit value 1 means output.
- R7: Pin inputs pass through a two-flop synchroniser. A read sampled at the same edge as the first sample of a changed input still returns the old value. A read issued three or more cycles after the change returns the new value.
- R8: When a read and a write to the data window are strobed in the same cycle, the read returns the state from before the write, and the write still takes effect.
- R9: Any other address is unmapped. This covers bits [11:10] = 1x, and bits [11:10] = 01 with a nonzero mask field. A write to an unmapped address changes neither `pin_out` nor `pin_oe`, and a read from it returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 32 | Write data; only bits 7:0 are used |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| pin_in | input | 8 | Raw pin input levels |
| pin_out | output | 8 | Output data register |
| pin_oe | output | 8 | Per-pin output enable (the direction register) |
| rd_data | output | 32 | Registered read data |

## Verification
A masked read and a masked write can land on the data window in the same cycle. The bench drives both strobes together with a mask that covers pins whose value is about to change. The read is then judged against the bench's model of the state before the write, and `pin_out` one edge later is judged against the state after it. An input change and a read can also coincide. The bench drives both on the same edge and expects the stale value, then reads again after the synchroniser has settled and expects the new one.

// File: rtl/gpm_pkg.sv
package gpm_pkg;
  // Which register an access addresses
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_DIR  = 2'd2
  } gpm_sel_e;
endpackage

// File: rtl/gpm_rst_sync.sv
module gpm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) chain_q <= '0;
    else          chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpm_addr_dec.sv
module gpm_addr_dec
  import gpm_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int PORT_W   = 8,
  parameter int MASK_LSB = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output gpm_sel_e          sel,
  output logic [PORT_W-1:0] mask
);
  localparam int MASK_MSB = MASK_LSB + PORT_W - 1;
  localparam int PAGE_W   = ADDR_W - MASK_MSB - 1;
  localparam logic [PAGE_W-1:0] PAGE_DATA = PAGE_W'(0);
  localparam logic [PAGE_W-1:0] PAGE_DIR  = PAGE_W'(1);

  logic [PAGE_W-1:0] page;
  logic              unused_byte_ofs;

  assign page            = addr[ADDR_W-1:MASK_MSB+1];
  assign mask            = addr[MASK_MSB:MASK_LSB];
  assign unused_byte_ofs = ^addr[MASK_LSB-1:0];   // R4: byte offset ignored

  always_comb begin
    sel = SEL_NONE;
    if (page == PAGE_DATA)                   sel = SEL_DATA;
    else if (page == PAGE_DIR && mask == '0) sel = SEL_DIR;
  end
endmodule

// File: rtl/gpm_in_sync.sv
module gpm_in_sync #(
  parameter int PORT_W = 8,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] pin_raw,
  output logic [PORT_W-1:0] pin_sync
);
  genvar g;
  generate
    for (g = 0; g < PORT_W; g++) begin : g_bit
      logic [STAGES-1:0] stage_q;
      logic [STAGES-1:0] stage_d;

      always_comb begin
        stage_d = {stage_q[STAGES-2:0], pin_raw[g]};
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
      end

      assign pin_sync[g] = stage_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/gpm_port_regs.sv
module gpm_port_regs
  import gpm_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  gpm_sel_e          sel,
  input  logic [PORT_W-1:0] mask,
  input  logic [PORT_W-1:0] wdata,
  output logic [PORT_W-1:0] out_q,
  output logic [PORT_W-1:0] dir_q
);
  logic              out_en;
  logic              dir_en;
  logic [PORT_W-1:0] out_d;
  logic [PORT_W-1:0] dir_d;

  // next-state
  always_comb begin
    out_en = wr_en && (sel == SEL_DATA);
    dir_en = wr_en && (sel == SEL_DIR);
    out_d  = (out_q & ~mask) | (wdata & mask);
    dir_d  = wdata;
  end

  // registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      out_q <= '0;
    else if (out_en) out_q <= out_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= '0;
    else if (dir_en) dir_q <= dir_d;
  end

  AST_UNMASKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((out_q & ~$past(mask)) == ($past(out_q) & ~$past(mask)))); // R2
  AST_MASKED_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_DATA) |=> ((out_q & $past(mask)) == ($past(wdata) & $past(mask)))); // R2
  AST_OUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && sel == SEL_DATA && mask != '0) |=> $stable(out_q)); // R3
  AST_DIR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && sel == SEL_DIR) |=> $stable(dir_q)); // R6
endmodule

// File: rtl/gpm_rd_path.sv
module gpm_rd_path
  import gpm_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int BUS_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  gpm_sel_e          sel,
  input  logic [PORT_W-1:0] mask,
  input  logic [PORT_W-1:0] out_q,
  input  logic [PORT_W-1:0] dir_q,
  input  logic [PORT_W-1:0] pin_sync,
  output logic [BUS_W-1:0]  rd_q
);
  localparam int PAD_W = BUS_W - PORT_W;

  logic [PORT_W-1:0] pin_view;
  logic [PORT_W-1:0] sel_val;
  logic [BUS_W-1:0]  rd_d;

  genvar g;
  generate
    for (g = 0; g < PORT_W; g++) begin : g_view
      assign pin_view[g] = dir_q[g] ? out_q[g] : pin_sync[g];
    end
  endgenerate

  always_comb begin
    unique case (sel)
      SEL_DATA: sel_val = pin_view & mask;
      SEL_DIR:  sel_val = dir_q;
      default:  sel_val = '0;
    endcase
    rd_d = {{PAD_W{1'b0}}, sel_val};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_d;
  end

  AST_RD_UNMASKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel == SEL_DATA) |=> ((rd_q[PORT_W-1:0] & ~$past(mask)) == '0)); // R5
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_q)); // R5
  AST_RD_PRE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel == SEL_DATA) |=> ((rd_q[PORT_W-1:0] & $past(mask) & $past(dir_q))
                                    == ($past(out_q) & $past(mask) & $past(dir_q)))); // R8
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gpm_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int BUS_W    = 32,
  parameter int PORT_W   = 8,
  parameter int MASK_LSB = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [PORT_W-1:0] pin_in,
  output logic [PORT_W-1:0] pin_out,
  output logic [PORT_W-1:0] pin_oe,
  output logic [BUS_W-1:0]  rd_data
);
  gpm_sel_e          acc_sel;
  logic [PORT_W-1:0] acc_mask;
  logic [PORT_W-1:0] pin_sync;
  logic [PORT_W-1:0] out_q;
  logic [PORT_W-1:0] dir_q;
  logic              rst_n_int;
  logic              unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[BUS_W-1:PORT_W];

  gpm_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_int)
  );

  gpm_addr_dec #(.ADDR_W(ADDR_W), .PORT_W(PORT_W), .MASK_LSB(MASK_LSB)) u_dec (
    .addr (bus_addr),
    .sel  (acc_sel),
    .mask (acc_mask)
  );

  gpm_in_sync #(.PORT_W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .pin_raw  (pin_in),
    .pin_sync (pin_sync)
  );

  gpm_port_regs #(.PORT_W(PORT_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_n_int),
    .wr_en (bus_wr),
    .sel   (acc_sel),
    .mask  (acc_mask),
    .wdata (bus_wdata[PORT_W-1:0]),
    .out_q (out_q),
    .dir_q (dir_q)
  );

  gpm_rd_path #(.PORT_W(PORT_W), .BUS_W(BUS_W)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .rd_en    (bus_rd),
    .sel      (acc_sel),
    .mask     (acc_mask),
    .out_q    (out_q),
    .dir_q    (dir_q),
    .pin_sync (pin_sync),
    .rd_q     (rd_data)
  );

  assign pin_out = out_q;
  assign pin_oe  = dir_q;

  AST_HIGH_PAGE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n_int)
    (bus_rd && bus_addr[ADDR_W-1]) |=> (rd_data == '0)); // R9
  AST_HIGH_PAGE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n_int)
    (bus_wr && bus_addr[ADDR_W-1]) |=> ($stable(pin_out) && $stable(pin_oe))); // R9
  AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n_int)
    bus_rd |=> (rd_data[BUS_W-1:PORT_W] == '0)); // R5
endmodule

// File: tb/gpio_mask_port_tb.sv
module gpio_mask_port_tb;
  logic        clk;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_wr;
  logic        bus_rd;
  logic [7:0]  pin_in;
  logic [7:0]  pin_out;
  logic [7:0]  pin_oe;
  logic [31:0] rd_data;

  gpio_mask_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;   // 200 MHz

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } rd_item_t;

  rd_item_t    rd_q[$];
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done  = 1'b0;
  logic        rd_seen;
  logic [7:0]  m_out;
  logic [7:0]  m_dir;

  localparam logic [11:0] DIR_ADDR = 12'h400;

  function automatic logic [11:0] data_addr(input logic [7:0] m);
    return {2'b00, m, 2'b00};
  endfunction

  function automatic logic [31:0] exp_data(input logic [7:0] m, input logic [7:0] pins);
    return {24'h0, m & ((m_dir & m_out) | (~m_dir & pins))};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = {24'hC3C3C3, d};
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, input logic [31:0] exp, input string tag);
    rd_item_t it;
    @(negedge clk);
    bus_addr = a;
    bus_rd   = 1'b1;
    it.exp = exp;
    it.tag = tag;
    rd_q.push_back(it);
    @(negedge clk);
    bus_rd   = 1'b0;
  endtask

  // monitor
  always @(posedge clk) rd_seen <= bus_rd;

  initial begin
    forever begin
      @(negedge clk);
      if (rd_seen === 1'b1) begin
        if (rd_q.size() == 0) begin
          check("read with no expected item", rd_data, 32'hx);
        end else begin
          rd_item_t it;
          it = rd_q.pop_front();
          check(it.tag, rd_data, it.exp);
        end
      end
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_wr = 1'b0; bus_rd = 1'b0;
    pin_in = 8'h00; m_out = 8'h00; m_dir = 8'h00;
    repeat (3) @(negedge clk);
    check("R1 pin_out in reset", {24'h0, pin_out}, 32'h0);
    check("R1 pin_oe in reset",  {24'h0, pin_oe},  32'h0);
    check("R1 rd_data in reset", rd_data, 32'h0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 pin_out after reset", {24'h0, pin_out}, 32'h0);
    check("R1 pin_oe after reset",  {24'h0, pin_oe},  32'h0);

    // R6: direction all outputs
    bus_write(DIR_ADDR, 8'hFF); m_dir = 8'hFF;
    check("R6 pin_oe", {24'h0, pin_oe}, 32'hFF);
    bus_read(DIR_ADDR, 32'hFF, "R6 dir readback");

    // R2: masked writes
    bus_write(data_addr(8'hFF), 8'hA5); m_out = 8'hA5;
    check("R2 full mask", {24'h0, pin_out}, {24'h0, m_out});
    bus_write(data_addr(8'h0F), 8'h00); m_out = (m_out & ~8'h0F);
    check("R2 clear low nibble", {24'h0, pin_out}, {24'h0, m_out});
    bus_write(data_addr(8'h3C), 8'h14); m_out = (m_out & ~8'h3C) | (8'h14 & 8'h3C);
    check("R2 mixed set/clear", {24'h0, pin_out}, {24'h0, m_out});

    // R3: zero mask
    bus_write(data_addr(8'h00), 8'hFF);
    check("R3 zero mask no change", {24'h0, pin_out}, {24'h0, m_out});

    // R4: byte offset bits
    bus_write(data_addr(8'h01) | 12'h003, 8'h01); m_out = m_out | 8'h01;
    check("R4 byte offset ignored on write", {24'h0, pin_out}, {24'h0, m_out});
    bus_read(data_addr(8'hFF) | 12'h002, exp_data(8'hFF, pin_in), "R4 byte offset ignored on read");

    // R5: masked reads
    bus_read(data_addr(8'hF0), exp_data(8'hF0, pin_in), "R5 read mask F0");
    bus_read(data_addr(8'h55), exp_data(8'h55, pin_in), "R5 read mask 55");
    bus_read(data_addr(8'h00), 32'h0, "R5 read mask 00");

    // R2: sweep of random masked writes
    for (int i = 0; i < 24; i++) begin
      logic [7:0] m;
      logic [7:0] d;
      m = 8'($urandom());
      d = 8'($urandom());
      bus_write(data_addr(m), d);
      m_out = (m_out & ~m) | (d & m);
      check("R2 sweep", {24'h0, pin_out}, {24'h0, m_out});
    end

    // R9: unmapped addresses
    bus_write(12'h800, 8'hFF);
    bus_write(12'h404, 8'h00);
    check("R9 unmapped write pin_out", {24'h0, pin_out}, {24'h0, m_out});
    check("R9 unmapped write pin_oe",  {24'h0, pin_oe},  {24'h0, m_dir});
    bus_read(12'h800, 32'h0, "R9 read high page");
    bus_read(12'h404, 32'h0, "R9 read dir page nonzero mask");
    bus_read(12'hC08, 32'h0, "R9 read top page");

    // R5/R6: mixed direction with settled inputs
    bus_write(DIR_ADDR, 8'h0F); m_dir = 8'h0F;
    check("R6 pin_oe partial", {24'h0, pin_oe}, 32'h0F);
    @(negedge clk); pin_in = 8'hA5;
    repeat (4) @(negedge clk);
    bus_read(data_addr(8'hFF), exp_data(8'hFF, 8'hA5), "R5 mixed direction");
    bus_read(data_addr(8'hC3), exp_data(8'hC3, 8'hA5), "R5 mixed direction masked");

    // R7: synchroniser latency
    @(negedge clk);
    pin_in   = 8'h5A;
    bus_addr = data_addr(8'hF0);
    bus_rd   = 1'b1;
    begin
      rd_item_t it;
      it.exp = exp_data(8'hF0, 8'hA5);
      it.tag = "R7 read at input change sees old";
      rd_q.push_back(it);
    end
    @(negedge clk); bus_rd = 1'b0;
    repeat (3) @(negedge clk);
    bus_read(data_addr(8'hF0), exp_data(8'hF0, 8'h5A), "R7 read after settle sees new");

    // R8: read and write in the same cycle
    bus_write(DIR_ADDR, 8'hFF); m_dir = 8'hFF;
    @(negedge clk);
    bus_addr  = data_addr(8'hFF);
    bus_wdata = {24'h0, ~m_out};
    bus_wr    = 1'b1;
    bus_rd    = 1'b1;
    begin
      rd_item_t it;
      it.exp = {24'h0, m_out};
      it.tag = "R8 read returns pre-write state";
      rd_q.push_back(it);
    end
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    m_out = ~m_out;
    check("R8 write still applied", {24'h0, pin_out}, {24'h0, m_out});
    bus_read(data_addr(8'hFF), {24'h0, m_out}, "R8 read after write");

    repeat (4) @(negedge clk);
    check("R5 no expected reads left", 32'(rd_q.size()), 32'h0);
    finish_run();
  end
endmodule